// File: doc/BRIEF.md
# Segment Access Guard

This block decides, before any address translation, whether one linear memory access is allowed under the segment it uses. It combines a cached segment descriptor (selector, base, limit and three attribute flags) with the access being made (start address, byte count and access kind) and the current processor mode. It produces a single fault flag and a 2-bit cause code. The decision is purely combinational, so a pipeline can put it in the same stage as the address generation that feeds it.

When protected mode is off, every access passes. Accesses also pass when long mode is active and the code segment runs 64-bit. In every other case the guard checks three things, in priority order. First, the selector must not be null. Second, for segment slots that carry attributes, the access kind must be allowed. Third, the access must lie inside the segment bounds. The bounds check follows the segment's direction. An expand-up segment limits the last byte of the access. An expand-down segment limits the end of the access, and the limit may lie numerically below the base, which wraps the valid window around.

Top module: `seg_guard`

## Requirements
- R1: With pe_i low, fault_o is 0 and cause_o is 2'b00, whatever the other inputs are.
- R2: With pe_i, lma_i and cs64_i all high, fault_o is 0 and cause_o is 2'b00. lma_i alone or cs64_i alone does not bypass the checks.
- R3: When checks are active and sel_i is zero, cause_o is 2'b01 (null selector). This holds even if a permission or bounds violation is also present.
- R4: When checks are active and seg_idx_i is in 0..6 (attribute slots), an access of kind 2'b01 (write) with wr_ok_i low gives cause_o 2'b10 (permission). A write with rd_ok_i low and wr_ok_i high is not refused.
- R5: In an attribute slot, an access of kind 2'b00 (read) or 2'b11 (treated as read) with rd_ok_i low gives cause_o 2'b10. Kind 2'b10 (execute) with rd_ok_i low is not refused.
- R6: For seg_idx_i of 7 or above, rd_ok_i, wr_ok_i and exp_down_i are ignored, and the segment is checked as expand-up.
- R7: For an expand-up segment, cause_o is 2'b11 (limit) exactly when addr_i + size_i - 1 exceeds limit_i. The sum is formed one bit wider than the address, so an access that runs past the top of the address space faults.
- R8: For an expand-down segment with limit_i >= base_i, cause_o is 2'b11 exactly when limit_i < addr_i + size_i (wide sum).
- R9: For an expand-down segment with limit_i < base_i, cause_o is 2'b11 exactly when limit_i < addr_i + size_i and addr_i < base_i.
- R10: fault_o is 1 exactly when cause_o is not 2'b00. The priority is null selector, then permission, then limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pe_i | input | 1 | Protected mode enabled |
| lma_i | input | 1 | Long mode active |
| cs64_i | input | 1 | Current code segment is 64-bit |
| sel_i | input | SEL_W (16) | Segment selector; zero means null |
| seg_idx_i | input | SEG_W (4) | Segment register slot; 0..ATTR_LAST carry attributes |
| base_i | input | ADDR_W (32) | Segment base |
| limit_i | input | ADDR_W (32) | Segment limit |
| rd_ok_i | input | 1 | Segment readable |
| wr_ok_i | input | 1 | Segment writable |
| exp_down_i | input | 1 | Segment expands down |
| addr_i | input | ADDR_W (32) | Access start address |
| size_i | input | SIZE_W (4) | Access size in bytes, 1 or more |
| kind_i | input | 2 | 00 read, 01 write, 10 execute, 11 read |
| fault_o | output | 1 | General-protection fault |
| cause_o | output | 2 | 00 none, 01 null selector, 10 permission, 11 limit |

## Verification
Two cases are hard to reach from the ports. The first is the wrapped expand-down window, where the limit is below the base. A fault there needs the access end above the limit and the start below the base at the same time. The second is an expand-up access whose last byte carries out past the top of the address space, which a narrow adder would wrap back to a small value that passes. Directed table vectors place accesses exactly on each bound, one byte either side, and at the address ceiling. A seeded sweep then biases base, limit and address into the same small range, so that wrapped and non-wrapped windows both show up often, and compares each result against a model built from the requirements.

// File: rtl/seg_guard_pkg.sv
package seg_guard_pkg;
  typedef enum logic [1:0] {
    ACC_RD  = 2'd0,
    ACC_WR  = 2'd1,
    ACC_EX  = 2'd2,
    ACC_RSV = 2'd3
  } acc_kind_e;

  typedef enum logic [1:0] {
    CZ_NONE  = 2'd0,
    CZ_NULL  = 2'd1,
    CZ_PERM  = 2'd2,
    CZ_LIMIT = 2'd3
  } cause_e;
endpackage

// File: rtl/seg_guard_mode.sv
module seg_guard_mode (
  input  logic pe_i,
  input  logic lma_i,
  input  logic cs64_i,
  output logic chk_en_o
);
  // Real mode and 64-bit code both skip segment checks
  assign chk_en_o = pe_i & ~(lma_i & cs64_i);
endmodule

// File: rtl/seg_guard_perm.sv
module seg_guard_perm
  import seg_guard_pkg::*;
#(
  parameter int SEG_W     = 4,
  parameter int ATTR_LAST = 6
) (
  input  logic [SEG_W-1:0] seg_idx_i,
  input  logic [1:0]       kind_i,
  input  logic             rd_ok_i,
  input  logic             wr_ok_i,
  input  logic             exp_down_i,
  output logic             perm_fault_o,
  output logic             exp_down_o
);
  localparam logic [SEG_W-1:0] LastSlot = SEG_W'(ATTR_LAST);

  acc_kind_e kind;
  logic      attr_slot;
  logic      is_wr;
  logic      is_plain_rd;

  assign kind        = acc_kind_e'(kind_i);
  assign attr_slot   = (seg_idx_i <= LastSlot);
  assign is_wr       = (kind == ACC_WR);
  assign is_plain_rd = (kind == ACC_RD) || (kind == ACC_RSV);

  always_comb begin
    perm_fault_o = 1'b0;
    if (attr_slot) begin
      if (is_wr && !wr_ok_i)       perm_fault_o = 1'b1;
      if (is_plain_rd && !rd_ok_i) perm_fault_o = 1'b1;
    end
  end

  // Slots without attributes are always expand-up
  assign exp_down_o = attr_slot & exp_down_i;
endmodule

// File: rtl/seg_guard_limit.sv
module seg_guard_limit #(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 4
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] limit_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic              exp_down_i,
  output logic              lim_fault_o
);
  localparam int EXT_W = ADDR_W + 1;

  logic [EXT_W-1:0] end_x;
  logic [EXT_W-1:0] last_x;
  logic [EXT_W-1:0] lim_x;
  logic             wrapped;
  logic             up_fault;
  logic             down_fault;

  assign end_x   = {1'b0, addr_i} + EXT_W'(size_i);
  assign last_x  = end_x - EXT_W'(1);
  assign lim_x   = {1'b0, limit_i};
  assign wrapped = (limit_i < base_i);

  assign up_fault = (last_x > lim_x);

  always_comb begin
    if (wrapped) down_fault = (lim_x < end_x) && (addr_i < base_i);
    else         down_fault = (lim_x < end_x);
  end

  assign lim_fault_o = exp_down_i ? down_fault : up_fault;
endmodule

// File: rtl/seg_guard.sv
module seg_guard
  import seg_guard_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int SIZE_W    = 4,
  parameter int SEL_W     = 16,
  parameter int SEG_W     = 4,
  parameter int ATTR_LAST = 6
) (
  input  logic              pe_i,
  input  logic              lma_i,
  input  logic              cs64_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [SEG_W-1:0]  seg_idx_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] limit_i,
  input  logic              rd_ok_i,
  input  logic              wr_ok_i,
  input  logic              exp_down_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic [1:0]        kind_i,
  output logic              fault_o,
  output logic [1:0]        cause_o
);
  logic   chk_en;
  logic   perm_fault;
  logic   eff_down;
  logic   lim_fault;
  cause_e cause;

  seg_guard_mode u_mode (
    .pe_i     (pe_i),
    .lma_i    (lma_i),
    .cs64_i   (cs64_i),
    .chk_en_o (chk_en)
  );

  seg_guard_perm #(
    .SEG_W     (SEG_W),
    .ATTR_LAST (ATTR_LAST)
  ) u_perm (
    .seg_idx_i    (seg_idx_i),
    .kind_i       (kind_i),
    .rd_ok_i      (rd_ok_i),
    .wr_ok_i      (wr_ok_i),
    .exp_down_i   (exp_down_i),
    .perm_fault_o (perm_fault),
    .exp_down_o   (eff_down)
  );

  seg_guard_limit #(
    .ADDR_W (ADDR_W),
    .SIZE_W (SIZE_W)
  ) u_limit (
    .base_i      (base_i),
    .limit_i     (limit_i),
    .addr_i      (addr_i),
    .size_i      (size_i),
    .exp_down_i  (eff_down),
    .lim_fault_o (lim_fault)
  );

  always_comb begin
    cause = CZ_NONE;
    if (chk_en) begin
      if (sel_i == '0)     cause = CZ_NULL;
      else if (perm_fault) cause = CZ_PERM;
      else if (lim_fault)  cause = CZ_LIMIT;
    end
  end

  assign cause_o = cause;
  assign fault_o = (cause != CZ_NONE);
endmodule

// File: rtl/seg_guard_chk.sv
module seg_guard_chk #(
  parameter int ADDR_W    = 32,
  parameter int SIZE_W    = 4,
  parameter int SEL_W     = 16,
  parameter int SEG_W     = 4,
  parameter int ATTR_LAST = 6
) (
  input logic              pe_i,
  input logic              lma_i,
  input logic              cs64_i,
  input logic [SEL_W-1:0]  sel_i,
  input logic [SEG_W-1:0]  seg_idx_i,
  input logic [ADDR_W-1:0] base_i,
  input logic [ADDR_W-1:0] limit_i,
  input logic              rd_ok_i,
  input logic              wr_ok_i,
  input logic              exp_down_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [SIZE_W-1:0] size_i,
  input logic [1:0]        kind_i,
  input logic              fault_o,
  input logic [1:0]        cause_o
);
  logic          act;
  logic          slot;
  logic [ADDR_W:0] top_x;
  logic [ADDR_W:0] lim_x;

  assign act   = pe_i && !(lma_i && cs64_i) && (sel_i != '0);
  assign slot  = (32'(seg_idx_i) <= ATTR_LAST);
  assign top_x = {1'b0, addr_i} + (ADDR_W+1)'(size_i);
  assign lim_x = {1'b0, limit_i};

  always_comb begin
    a_r1_real_bypass: assert (pe_i || !fault_o)
      else $error("R1 fault in real mode");
    a_r2_long_bypass: assert (!(pe_i && lma_i && cs64_i) || !fault_o)
      else $error("R2 fault in 64-bit mode");
    a_r3_null_sel: assert (!(pe_i && !(lma_i && cs64_i) && sel_i == '0) || cause_o == 2'b01)
      else $error("R3 null selector not reported");
    a_r4_write_perm: assert (!(act && slot && kind_i == 2'b01 && !wr_ok_i) || cause_o == 2'b10)
      else $error("R4 write to read-only segment not refused");
    a_r5_read_perm: assert (!(act && slot && !kind_i[1] && !kind_i[0] && !rd_ok_i) || cause_o == 2'b10)
      else $error("R5 read of unreadable segment not refused");
    a_r7_up_limit: assert (!(act && !slot && (top_x - 1'b1) > lim_x) || cause_o == 2'b11)
      else $error("R7 expand-up overrun not refused");
    a_r9_wrap_inside: assert (!(act && slot && exp_down_i && limit_i < base_i && addr_i >= base_i) || cause_o != 2'b11)
      else $error("R9 access above base refused in wrapped window");
    a_r10_flag_cause: assert (fault_o == (cause_o != 2'b00))
      else $error("R10 fault flag and cause disagree");
  end
endmodule

bind seg_guard seg_guard_chk #(
  .ADDR_W    (ADDR_W),
  .SIZE_W    (SIZE_W),
  .SEL_W     (SEL_W),
  .SEG_W     (SEG_W),
  .ATTR_LAST (ATTR_LAST)
) u_chk (.*);

// File: tb/tb_seg_guard.sv
module tb_seg_guard;
  localparam int ADDR_W = 32;
  localparam int SIZE_W = 4;
  localparam int SEL_W  = 16;
  localparam int SEG_W  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic              pe, lma, cs64, rd_ok, wr_ok, exp_dn, fault;
  logic [SEL_W-1:0]  sel;
  logic [SEG_W-1:0]  seg;
  logic [ADDR_W-1:0] base, limit, addr;
  logic [SIZE_W-1:0] size;
  logic [1:0]        kind, cause;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  seg_guard dut (
    .pe_i(pe), .lma_i(lma), .cs64_i(cs64), .sel_i(sel), .seg_idx_i(seg),
    .base_i(base), .limit_i(limit), .rd_ok_i(rd_ok), .wr_ok_i(wr_ok),
    .exp_down_i(exp_dn), .addr_i(addr), .size_i(size), .kind_i(kind),
    .fault_o(fault), .cause_o(cause)
  );

  typedef struct packed {
    logic [7:0]  req;
    logic        pe, lma, cs64;
    logic [15:0] sel;
    logic [3:0]  seg;
    logic [1:0]  kind;
    logic        rd, wr, ed;
    logic [31:0] base, limit, addr;
    logic [3:0]  size;
    logic [1:0]  exp;
  } vec_t;

  localparam int NV = 28;
  // req, pe,lma,cs64, sel, seg, kind, rd,wr,ed, base, limit, addr, size, expected cause
  localparam vec_t VECS [NV] = '{
    '{8'd1,  1'b0,1'b0,1'b0, 16'h0000, 4'd3, 2'd1, 1'b1,1'b0,1'b0, 32'h0, 32'h0000FFFF, 32'h00020000, 4'd4, 2'd0}, // R1
    '{8'd2,  1'b1,1'b1,1'b1, 16'h0000, 4'd3, 2'd1, 1'b0,1'b0,1'b0, 32'h0, 32'h0000FFFF, 32'h00020000, 4'd4, 2'd0}, // R2
    '{8'd2,  1'b1,1'b1,1'b0, 16'h0000, 4'd3, 2'd0, 1'b1,1'b1,1'b0, 32'h0, 32'h0000FFFF, 32'h00000100, 4'd4, 2'd1}, // R2
    '{8'd2,  1'b1,1'b0,1'b1, 16'h0000, 4'd3, 2'd0, 1'b1,1'b1,1'b0, 32'h0, 32'h0000FFFF, 32'h00000100, 4'd4, 2'd1}, // R2
    '{8'd3,  1'b1,1'b0,1'b0, 16'h0000, 4'd3, 2'd1, 1'b1,1'b0,1'b0, 32'h0, 32'h00000010, 32'h00002000, 4'd4, 2'd1}, // R3
    '{8'd4,  1'b1,1'b0,1'b0, 16'h0008, 4'd3, 2'd1, 1'b1,1'b0,1'b0, 32'h0, 32'h0000FFFF, 32'h00000100, 4'd4, 2'd2}, // R4
    '{8'd4,  1'b1,1'b0,1'b0, 16'h0008, 4'd3, 2'd1, 1'b0,1'b1,1'b0, 32'h0, 32'h0000FFFF, 32'h00000100, 4'd4, 2'd0}, // R4
    '{8'd5,  1'b1,1'b0,1'b0, 16'h0008, 4'd0, 2'd0, 1'b0,1'b1,1'b0, 32'h0, 32'h0000FFFF, 32'h00000100, 4'd4, 2'd2}, // R5
    '{8'd5,  1'b1,1'b0,1'b0, 16'h0008, 4'd1, 2'd2, 1'b0,1'b0,1'b0, 32'h0, 32'h0000FFFF, 32'h00000100, 4'd4, 2'd0}, // R5
    '{8'd5,  1'b1,1'b0,1'b0, 16'h0008, 4'd3, 2'd3, 1'b0,1'b1,1'b0, 32'h0, 32'h0000FFFF, 32'h00000100, 4'd4, 2'd2}, // R5
    '{8'd6,  1'b1,1'b0,1'b0, 16'h0008, 4'd8, 2'd1, 1'b0,1'b0,1'b0, 32'h0, 32'h0000FFFF, 32'h00000100, 4'd4, 2'd0}, // R6
    '{8'd6,  1'b1,1'b0,1'b0, 16'h0008, 4'd8, 2'd0, 1'b1,1'b1,1'b1, 32'h0, 32'h00001000, 32'h00002000, 4'd4, 2'd3}, // R6
    '{8'd6,  1'b1,1'b0,1'b0, 16'h0008, 4'd6, 2'd1, 1'b1,1'b0,1'b0, 32'h0, 32'h0000FFFF, 32'h00000100, 4'd4, 2'd2}, // R6
    '{8'd6,  1'b1,1'b0,1'b0, 16'h0008, 4'd7, 2'd1, 1'b1,1'b0,1'b0, 32'h0, 32'h0000FFFF, 32'h00000100, 4'd4, 2'd0}, // R6
    '{8'd7,  1'b1,1'b0,1'b0, 16'h0008, 4'd3, 2'd0, 1'b1,1'b1,1'b0, 32'h0, 32'h0000FFFF, 32'h0000FFFC, 4'd4, 2'd0}, // R7
    '{8'd7,  1'b1,1'b0,1'b0, 16'h0008, 4'd3, 2'd0, 1'b1,1'b1,1'b0, 32'h0, 32'h0000FFFF, 32'h0000FFFD, 4'd4, 2'd3}, // R7
    '{8'd7,  1'b1,1'b0,1'b0, 16'h0008, 4'd3, 2'd0, 1'b1,1'b1,1'b0, 32'h0, 32'hFFFFFFFF, 32'hFFFFFFFC, 4'd4, 2'd0}, // R7
    '{8'd7,  1'b1,1'b0,1'b0, 16'h0008, 4'd3, 2'd0, 1'b1,1'b1,1'b0, 32'h0, 32'hFFFFFFFE, 32'hFFFFFFFC, 4'd4, 2'd3}, // R7
    '{8'd7,  1'b1,1'b0,1'b0, 16'h0008, 4'd3, 2'd0, 1'b1,1'b1,1'b0, 32'h0, 32'hFFFFFFFF, 32'hFFFFFFFF, 4'd2, 2'd3}, // R7 carry out
    '{8'd8,  1'b1,1'b0,1'b0, 16'h0008, 4'd3, 2'd0, 1'b1,1'b1,1'b1, 32'h1000, 32'h00008000, 32'h00009000, 4'd4, 2'd3}, // R8
    '{8'd8,  1'b1,1'b0,1'b0, 16'h0008, 4'd3, 2'd0, 1'b1,1'b1,1'b1, 32'h1000, 32'h00008000, 32'h00007000, 4'd4, 2'd0}, // R8
    '{8'd8,  1'b1,1'b0,1'b0, 16'h0008, 4'd3, 2'd0, 1'b1,1'b1,1'b1, 32'h1000, 32'h00008000, 32'h00007FFC, 4'd4, 2'd0}, // R8
    '{8'd8,  1'b1,1'b0,1'b0, 16'h0008, 4'd3, 2'd0, 1'b1,1'b1,1'b1, 32'h1000, 32'h00008000, 32'h00007FFD, 4'd4, 2'd3}, // R8
    '{8'd9,  1'b1,1'b0,1'b0, 16'h0008, 4'd3, 2'd0, 1'b1,1'b1,1'b1, 32'h8000, 32'h00001000, 32'h00002000, 4'd4, 2'd3}, // R9
    '{8'd9,  1'b1,1'b0,1'b0, 16'h0008, 4'd3, 2'd0, 1'b1,1'b1,1'b1, 32'h8000, 32'h00001000, 32'h00009000, 4'd4, 2'd0}, // R9
    '{8'd9,  1'b1,1'b0,1'b0, 16'h0008, 4'd3, 2'd0, 1'b1,1'b1,1'b1, 32'h8000, 32'h00001000, 32'h00000FF0, 4'd4, 2'd0}, // R9
    '{8'd10, 1'b1,1'b0,1'b0, 16'h0008, 4'd3, 2'd0, 1'b0,1'b1,1'b0, 32'h0, 32'h00000010, 32'h00002000, 4'd4, 2'd2}, // R10
    '{8'd10, 1'b1,1'b0,1'b0, 16'h0008, 4'd3, 2'd2, 1'b0,1'b1,1'b0, 32'h0, 32'h00000010, 32'h00002000, 4'd4, 2'd3}  // R10
  };

  function automatic logic [1:0] model(vec_t v);
    logic slot, ed, f;
    logic [32:0] e, l;
    if (!v.pe || (v.lma && v.cs64)) return 2'd0;
    if (v.sel == 16'h0) return 2'd1;
    slot = (v.seg <= 4'd6);
    if (slot && v.kind == 2'd1 && !v.wr) return 2'd2;
    if (slot && (v.kind == 2'd0 || v.kind == 2'd3) && !v.rd) return 2'd2;
    ed = slot && v.ed;
    e  = {1'b0, v.addr} + {29'd0, v.size};
    l  = {1'b0, v.limit};
    if (ed) f = (v.limit < v.base) ? ((l < e) && (v.addr < v.base)) : (l < e);
    else    f = (e - 33'd1) > l;
    return f ? 2'd3 : 2'd0;
  endfunction

  task automatic apply(vec_t v);
    @(negedge clk);
    pe = v.pe; lma = v.lma; cs64 = v.cs64; sel = v.sel; seg = v.seg;
    kind = v.kind; rd_ok = v.rd; wr_ok = v.wr; exp_dn = v.ed;
    base = v.base; limit = v.limit; addr = v.addr; size = v.size;
    #1;
  endtask

  task automatic check(string tag, logic [1:0] exp_c);
    n_chk++;
    if (cause !== exp_c) begin
      n_bad++;
      $display("FAIL %s cause actual=%0d expected=%0d", tag, cause, exp_c);
    end
    n_chk++;
    if (fault !== (exp_c != 2'd0)) begin
      n_bad++;
      $display("FAIL %s fault actual=%0b expected=%0b", tag, fault, exp_c != 2'd0);
    end
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < 200000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    vec_t v;
    int unsigned seed;
    pe = 0; lma = 0; cs64 = 0; sel = '0; seg = '0; kind = '0;
    rd_ok = 0; wr_ok = 0; exp_dn = 0; base = '0; limit = '0; addr = '0; size = '0;
    repeat (4) @(posedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 reset idle", 2'd0);

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i]);
      check($sformatf("R%0d vec%0d", VECS[i].req, i), VECS[i].exp);
    end

    // R10 seeded sweep against the requirement model
    seed = 32'h5E61;
    void'($urandom(seed));
    for (int i = 0; i < 600; i++) begin
      v.req  = 8'd10;
      v.pe   = ($urandom % 8) != 0;
      v.lma  = ($urandom % 3) == 0;
      v.cs64 = ($urandom % 3) == 0;
      v.sel  = (($urandom % 6) == 0) ? 16'h0 : 16'($urandom);
      v.seg  = 4'($urandom % 10);
      v.kind = 2'($urandom);
      v.rd   = ($urandom % 5) != 0;
      v.wr   = ($urandom % 5) != 0;
      v.ed   = $urandom % 2;
      if (($urandom % 4) == 0) begin
        v.base  = 32'hFFFFFF00 | 32'($urandom % 256);
        v.limit = 32'hFFFFFF00 | 32'($urandom % 256);
        v.addr  = 32'hFFFFFF00 | 32'($urandom % 256);
      end else begin
        v.base  = 32'($urandom % 256);
        v.limit = 32'($urandom % 256);
        v.addr  = 32'($urandom % 256);
      end
      v.size = 4'(1 + ($urandom % 8));
      v.exp  = model(v);
      apply(v);
      check($sformatf("R10 sweep%0d", i), v.exp);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule